// File: doc/BRIEF.md
# Packed Instruction Image Loader

This engine moves a program image from a data memory whose words are 34 bits wide into an instruction memory whose entries are 17 bits wide. Every data word carries two instructions. After a start request the engine fetches one data word at a time, cuts it into its two halves and stores them at two neighbouring instruction addresses. It then signals completion with a one-cycle pulse.

The caller supplies three values with the start pulse: a source data-word address, a destination instruction address and an instruction count. The engine latches these values when it accepts the request. A new request can only be accepted once the engine is idle again. Both address spaces are 34 bits wide and wrap modulo 2^34. Each data word takes three cycles: one read cycle followed by two write cycles.

Top module: `pkimg_loader`

## Requirements
- R1: While reset is held and after its release, busy, done, the read enable and the write enable are all low.
- R2: A start pulse seen while idle latches the source address, destination address and count, and the first data read appears in the cycle right after that start edge, at the latched source address.
- R3: For each data word, bits [33:17] are written to the current destination address, and bits [16:0] go to the next destination address in the following cycle.
- R4: The source address increases by one per data word read and the destination address by one per instruction written, both wrapping modulo 2^34.
- R5: Exactly count instructions are written, using count/2 data reads. Bit 0 of the count is ignored, so an odd count is rounded down to the next even value.
- R6: A count of zero (or one) performs no reads and no writes, and the done pulse appears in the cycle right after the start edge.
- R7: Done is high for exactly one cycle, in the cycle after the final write, and busy is low from the following cycle on.
- R8: A start pulse while busy is ignored: the running transfer keeps its addresses and count.
- R9: Read data is taken one cycle after the read enable. Each read is followed at once by its two writes, so successive data words start three cycles apart.
- R10: In any cycle at most one of read enable, write enable and done is high, and no memory access happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a transfer; only taken while idle |
| src_addr_i | input | 34 | First data-word address to read |
| dst_addr_i | input | 34 | First instruction address to write |
| count_i | input | 34 | Number of instructions to copy (LSB ignored) |
| busy_o | output | 1 | High from acceptance until the done cycle inclusive |
| done_o | output | 1 | One-cycle completion pulse |
| dm_rd_en_o | output | 1 | Data memory read request |
| dm_rd_addr_o | output | 34 | Data memory read address |
| dm_rd_data_i | input | 34 | Data memory read data, valid one cycle after the request |
| im_wr_en_o | output | 1 | Instruction memory write enable |
| im_wr_addr_o | output | 34 | Instruction memory write address |
| im_wr_data_o | output | 17 | Instruction memory write data |

## Verification
The assertions check the local rules on every cycle. Only one of read, write and done may be active in a cycle, and nothing may be active while idle. Each read must be followed directly by a write. The two writes of a pair must go to neighbouring addresses. Done must last exactly one cycle, and a start pulse must not disturb a busy engine. Other properties span a whole transfer and are left to the bench scenarios: the halves must be written in the right order with the right data, the source and destination addresses must wrap across 2^34, the total read and write counts must match the requested count (including the odd-count and zero-count cases), and done must arrive in the exact cycle.

// File: rtl/pkimg_pkg.sv
// Package: shared types for the packed instruction image loader.
// Assumes nothing beyond a single clock domain.
package pkimg_pkg;
    typedef enum logic [2:0] {
        LS_IDLE = 3'd0,
        LS_READ = 3'd1,
        LS_HI   = 3'd2,
        LS_LO   = 3'd3,
        LS_FIN  = 3'd4
    } ldr_state_t;
endpackage

// File: rtl/pkimg_ctrl.sv
// Controller: sequences read / high write / low write per data word and
// counts remaining words. Assumes read data arrives one cycle after READ.
module pkimg_ctrl
    import pkimg_pkg::*;
#(
    parameter int CNT_W = 34
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [CNT_W-1:0] count_i,
    output ldr_state_t state_o,
    output logic       load_o
);
    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(1);

    ldr_state_t       state_q;
    logic [CNT_W-1:0] words_left_q;
    logic [CNT_W-1:0] words_req;

    // Number of data words requested; the LSB of the count is dropped.
    assign words_req = count_i >> 1;
    assign load_o    = (state_q == LS_IDLE) && start_i;
    assign state_o   = state_q;

    // State register and remaining-word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= LS_IDLE;
            words_left_q <= '0;
        end else begin
            unique case (state_q)
                LS_IDLE: if (start_i) begin
                    words_left_q <= words_req;
                    state_q      <= (words_req == '0) ? LS_FIN : LS_READ;
                end
                LS_READ: state_q <= LS_HI;
                LS_HI:   state_q <= LS_LO;
                LS_LO: begin
                    words_left_q <= words_left_q - ONE_WORD;
                    state_q      <= (words_left_q == ONE_WORD) ? LS_FIN : LS_READ;
                end
                LS_FIN:  state_q <= LS_IDLE;
                default: state_q <= LS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkimg_addr.sv
// Address counters: source word pointer and destination instruction pointer.
// Both wrap naturally at their width.
module pkimg_addr #(
    parameter int AW  = 34,
    parameter int IAW = 34
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [AW-1:0]  src_i,
    input  logic [IAW-1:0] dst_i,
    input  logic           src_step_i,
    input  logic           dst_step_i,
    output logic [AW-1:0]  src_o,
    output logic [IAW-1:0] dst_o
);
    logic [AW-1:0]  src_q;
    logic [IAW-1:0] dst_q;

    // Load on acceptance, step once per read or per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else begin
            if (load_i)          src_q <= src_i;
            else if (src_step_i) src_q <= src_q + AW'(1);
            if (load_i)          dst_q <= dst_i;
            else if (dst_step_i) dst_q <= dst_q + IAW'(1);
        end
    end

    assign src_o = src_q;
    assign dst_o = dst_q;
endmodule

// File: rtl/pkimg_split.sv
// Half selector: passes the upper half of the incoming word straight
// through and keeps the lower half for the following cycle.
// Assumes the word is exactly twice the instruction width.
module pkimg_split #(
    parameter int IW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic          sel_lo_i,
    input  logic [2*IW-1:0] word_i,
    output logic [IW-1:0] half_o
);
    logic [IW-1:0] halves [2];
    logic [IW-1:0] lo_hold_q;

    // Slice the word into its two halves (index 1 = upper).
    for (genvar g = 0; g < 2; g++) begin : g_half
        assign halves[g] = word_i[g*IW +: IW];
    end

    // Keep the lower half while the upper half is written.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_hold_q <= '0;
        else if (cap_i) lo_hold_q <= halves[0];
    end

    // Select the upper half live, or the kept lower half.
    always_comb begin
        half_o = sel_lo_i ? lo_hold_q : halves[1];
    end
endmodule

// File: rtl/pkimg_loader.sv
// Top: copies count instructions from a two-per-word data memory into an
// instruction memory. Assumes a data memory read latency of one cycle.
module pkimg_loader
    import pkimg_pkg::*;
#(
    parameter int AW    = 34,
    parameter int IAW   = 34,
    parameter int CNT_W = 34,
    parameter int IW    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    src_addr_i,
    input  logic [IAW-1:0]   dst_addr_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             dm_rd_en_o,
    output logic [AW-1:0]    dm_rd_addr_o,
    input  logic [2*IW-1:0]  dm_rd_data_i,
    output logic             im_wr_en_o,
    output logic [IAW-1:0]   im_wr_addr_o,
    output logic [IW-1:0]    im_wr_data_o
);
    ldr_state_t st;
    logic       load;
    logic       in_read, in_hi, in_lo;

    pkimg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .state_o(st), .load_o(load)
    );

    assign in_read = (st == LS_READ);
    assign in_hi   = (st == LS_HI);
    assign in_lo   = (st == LS_LO);

    pkimg_addr #(.AW(AW), .IAW(IAW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .src_i(src_addr_i), .dst_i(dst_addr_i),
        .src_step_i(in_read), .dst_step_i(in_hi | in_lo),
        .src_o(dm_rd_addr_o), .dst_o(im_wr_addr_o)
    );

    pkimg_split #(.IW(IW)) u_split (
        .clk(clk), .rst_n(rst_n), .cap_i(in_hi), .sel_lo_i(in_lo),
        .word_i(dm_rd_data_i), .half_o(im_wr_data_o)
    );

    assign busy_o     = (st != LS_IDLE);
    assign done_o     = (st == LS_FIN);
    assign dm_rd_en_o = in_read;
    assign im_wr_en_o = in_hi | in_lo;
endmodule

// File: rtl/pkimg_loader_chk.sv
// Checker: cycle-level protocol properties of the loader, bound to the top.
module pkimg_loader_chk #(
    parameter int IAW = 34
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           dm_rd_en_o,
    input logic           im_wr_en_o,
    input logic [IAW-1:0] im_wr_addr_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!dm_rd_en_o && !im_wr_en_o && !done_o)); // R10
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dm_rd_en_o, im_wr_en_o, done_o}) <= 1); // R10
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd_en_o |=> (im_wr_en_o && !dm_rd_en_o)); // R9
    AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
        (im_wr_en_o && $past(im_wr_en_o)) |-> (im_wr_addr_o == $past(im_wr_addr_o) + IAW'(1))); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o)); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R8
endmodule

bind pkimg_loader pkimg_loader_chk #(.IAW(IAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .dm_rd_en_o(dm_rd_en_o), .im_wr_en_o(im_wr_en_o),
    .im_wr_addr_o(im_wr_addr_o)
);

// File: tb/sim_pkimg_loader.sv
module sim_pkimg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [33:0] TV_SRC [NV] = '{34'd0, 34'd5, 34'h3_FFFF_FFFE, 34'd10, 34'd3, 34'd1};
    localparam logic [33:0] TV_DST [NV] = '{34'd0, 34'd100, 34'h3_FFFF_FFFD, 34'd7, 34'd40, 34'd2};
    localparam logic [33:0] TV_CNT [NV] = '{34'd8, 34'd2, 34'd6, 34'd12, 34'd0, 34'd5};

    logic clk = 0, rst_n = 0, start = 0;
    logic [33:0] src = '0, dst = '0, cnt = '0;
    logic busy, done, rd_en, wr_en;
    logic [33:0] rd_addr, wr_addr, rd_data;
    logic [16:0] wr_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int nrd = 0, nwr = 0, ndone = 0, done_cyc = 0, n_proto = 0;
    logic [33:0] log_rd_addr [64];
    int          log_rd_cyc  [64];
    logic [33:0] log_wr_addr [64];
    logic [16:0] log_wr_data [64];
    int          log_wr_cyc  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkimg_loader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_addr_i(src),
        .dst_addr_i(dst), .count_i(cnt), .busy_o(busy), .done_o(done),
        .dm_rd_en_o(rd_en), .dm_rd_addr_o(rd_addr), .dm_rd_data_i(rd_data),
        .im_wr_en_o(wr_en), .im_wr_addr_o(wr_addr), .im_wr_data_o(wr_data)
    );

    function automatic logic [33:0] dm_word(input logic [3:0] i);
        return {17'h15A00 + 17'(i), 17'h00300 + 17'(2 * i)};
    endfunction

    // Data memory model: one-cycle read latency, 16 words aliased.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rd_en) rd_data <= dm_word(rd_addr[3:0]);
    end

    // Port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rd_en && nrd < 64) begin
            log_rd_addr[nrd] = rd_addr; log_rd_cyc[nrd] = cyc; nrd++;
        end
        if (wr_en && nwr < 64) begin
            log_wr_addr[nwr] = wr_addr; log_wr_data[nwr] = wr_data;
            log_wr_cyc[nwr] = cyc; nwr++;
        end
        if (done) begin ndone++; done_cyc = cyc; end
        if ((int'(rd_en) + int'(wr_en) + int'(done)) > 1) n_proto++;
        if (!busy && (rd_en || wr_en || done)) n_proto++;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [33:0] s, input logic [33:0] d,
                            input logic [33:0] c, input bit inject);
        int scyc, p;
        logic [33:0] w;
        @(posedge clk);
        nrd = 0; nwr = 0; ndone = 0;
        @(negedge clk);
        src = s; dst = d; cnt = c; start = 1; scyc = cyc;
        @(negedge clk);
        start = 0;
        if (inject) begin
            src = 34'd9; dst = 34'd900; cnt = 34'd0; start = 1; // R8
            @(negedge clk);
            start = 0;
        end
        for (int n = 0; n < 300; n++) begin
            @(posedge clk);
            if (ndone != 0) break;
        end
        repeat (3) @(posedge clk);
        #1;
        p = int'(c >> 1);
        chk(ndone == 1, "R7 done pulses", ndone, 1);
        chk(done_cyc == scyc + 1 + 3 * p, "R7/R6 done cycle", done_cyc, scyc + 1 + 3 * p);
        chk(busy == 1'b0, "R7 idle after done", busy, 0);
        chk(nrd == p, "R5 read count", nrd, p);
        chk(nwr == 2 * p, "R5 write count", nwr, 2 * p);
        for (int k = 0; k < p && k < nrd; k++) begin
            chk(log_rd_addr[k] == s + 34'(k), "R4/R2 read address", log_rd_addr[k], s + 34'(k));
            chk(log_rd_cyc[k] == scyc + 1 + 3 * k, "R2/R9 read cycle", log_rd_cyc[k], scyc + 1 + 3 * k);
        end
        for (int j = 0; j < 2 * p && j < nwr; j++) begin
            w = dm_word(4'(s + 34'(j / 2)));
            chk(log_wr_addr[j] == d + 34'(j), "R4 write address", log_wr_addr[j], d + 34'(j));
            chk(log_wr_data[j] == ((j % 2 == 0) ? w[33:17] : w[16:0]), "R3 split order",
                log_wr_data[j], (j % 2 == 0) ? w[33:17] : w[16:0]);
            chk(log_wr_cyc[j] == scyc + 2 + 3 * (j / 2) + (j % 2), "R9 write cycle",
                log_wr_cyc[j], scyc + 2 + 3 * (j / 2) + (j % 2));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL WATCHDOG actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1 in reset", {busy, done, rd_en, wr_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1 after reset", {busy, done, rd_en, wr_en}, 0);
        // Table walk: normal, single word, wrap, long, zero (R6), odd (R5).
        for (int v = 0; v < NV; v++) run_case(TV_SRC[v], TV_DST[v], TV_CNT[v], 1'b0);
        // Directed: start while busy must be ignored (R8).
        run_case(34'd4, 34'd20, 34'd4, 1'b1);
        // Directed: count of one behaves as zero (R6).
        run_case(34'd2, 34'd50, 34'd1, 1'b0);
        chk(n_proto == 0, "R10 exclusive activity", n_proto, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule